// File: doc/BRIEF.md
# Configurable External Bus Cycle Controller

This block turns single read or write requests from an internal master into cycles on an external memory bus. A 16-bit configuration word, written through a simple write port, sets the shape of every cycle. It selects one of four bus types (8 or 16 data bits, with address and data on shared or on separate lines), the length of the address-latch pulse, an optional idle clock before the strobe, the number of wait clocks, an optional recovery clock after the strobe, and whether the strobe ends on a count or on an external ready line of chosen polarity.

A cycle runs through a fixed sequence of one-clock phases: address latch (one or two clocks), an optional gap, the data strobe (one or more clocks), and an optional turnaround clock. The configuration is copied when a request is accepted, so a write to the configuration word during a cycle shapes only later cycles. Read data is taken from the shared lines on the last strobe clock, and a one-clock `done` pulse follows in the next clock.

Top module: `ebc_top`

## Requirements
- R1: The configuration word resets to 0000h and is replaced on any clock with `cfg_we` high. Field positions: bit 0 enables the bus; bits 2:1 give the bus type; bit 3 lengthens the latch pulse; bit 4 removes the gap; bit 5 makes `ready_i` end the strobe; bit 6 is the active level of `ready_i`; bit 7 removes the turnaround clock; bit 8 gates `bus_cs` to the read strobe; bit 9 gates `bus_cs` to the write strobe; bits 15:12 are the wait code; bits 11:10 are ignored.
- R2: While bit 0 is clear, a request is ignored: `busy`, `bus_ale`, `bus_rd`, `bus_wr`, `bus_cs` and `done` stay low.
- R3: The cycle starts in the clock after the request is sampled, with `bus_ale` high for one clock, or two clocks when bit 3 is set.
- R4: With bit 4 clear, exactly one clock with no latch pulse and no strobe lies between `bus_ale` and the strobe; with bit 4 set, the strobe follows `bus_ale` directly.
- R5: With bit 5 clear, `bus_rd` (read) or `bus_wr` (write) stays high for 16 minus the wait code clocks: code 0 gives 16 clocks, code 15 gives 1.
- R6: With bit 5 set, the strobe ends in the clock in which `ready_i` equals bit 6 at the rising edge, whatever the wait code.
- R7: With bit 7 clear, one more clock with `busy` high and every strobe low follows the strobe; with bit 7 set, none does.
- R8: Bus type bit 1 is the multiplexed flag and bit 2 the 16-bit flag (00 8-bit separate, 01 8-bit shared, 10 16-bit separate, 11 16-bit shared). When shared, every latch clock drives the low address bits on `ad_o` with `ad_oe` high and `addr_o` is zero; when separate, `ad_oe` stays low during the latch pulse and `addr_o` carries the address from the latch pulse to the end of the strobe.
- R9: During a write strobe `ad_oe` is high and `ad_o` carries the write data; on an 8-bit bus the upper byte is zero, and read data is returned as the low byte of `ad_i` with the upper byte zero.
- R10: With the gate bit for the cycle's direction clear, `bus_cs` is high from the first latch clock to the last strobe clock; with it set, `bus_cs` is high only while the strobe is high.
- R11: `rdata` takes `ad_i` at the edge ending the last read strobe clock and holds it; `done` is high for exactly one clock, the clock right after the last strobe clock.
- R12: A configuration write during a cycle leaves that cycle unchanged; `bus_rd` and `bus_wr` are never high together, and neither is high with `bus_ale`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_wdata | input | 16 | New configuration word |
| req | input | 1 | Request, sampled while not busy |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Last read data |
| bus_ale | output | 1 | Address latch pulse |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_cs | output | 1 | Chip select, active high |
| addr_o | output | ADDR_W | Separate address lines |
| ad_o | output | DATA_W | Shared address/data lines, driven value |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| ad_i | input | DATA_W | Shared address/data lines, sampled value |
| ready_i | input | 1 | External ready, synchronous to `clk` |

## Verification
The assertions take `ready_i` to be synchronous to `clk` and `req` to be raised only while `busy` is low, so an accepted request is never held into a running cycle. The bench drives every input at the falling edge, pulses `req` for a single clock while idle, and changes `ready_i` only during the strobe of a cycle that uses it, setting it back to the inactive level before the next request. Configuration writes are made in idle except for the one directed test of R12, which writes during the latch phase.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    localparam int unsigned CFG_W  = 16;
    localparam int unsigned WAIT_W = 4;

    // configuration word layout
    localparam int unsigned CB_ON       = 0;
    localparam int unsigned CB_KIND     = 1;
    localparam int unsigned CB_ALE_LONG = 3;
    localparam int unsigned CB_NODLY    = 4;
    localparam int unsigned CB_RDY_USE  = 5;
    localparam int unsigned CB_RDY_HIGH = 6;
    localparam int unsigned CB_TRI_SKIP = 7;
    localparam int unsigned CB_CS_RD    = 8;
    localparam int unsigned CB_CS_WR    = 9;
    localparam int unsigned CB_WAIT     = 12;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ALE  = 3'd1,
        PH_HOLD = 3'd2,
        PH_GAP  = 3'd3,
        PH_DATA = 3'd4,
        PH_TURN = 3'd5
    } phase_e;

    typedef struct packed {
        logic [WAIT_W-1:0] wait_code;
        logic              cs_wr_gate;
        logic              cs_rd_gate;
        logic              tri_skip;
        logic              rdy_high;
        logic              rdy_use;
        logic              rw_nodelay;
        logic              ale_long;
        logic [1:0]        kind;      // [0] shared lines, [1] 16-bit
        logic              bus_on;
    } bus_cfg_t;

    function automatic bus_cfg_t cfg_decode(input logic [CFG_W-1:0] w);
        bus_cfg_t c;
        c.wait_code  = w[CB_WAIT +: WAIT_W];
        c.cs_wr_gate = w[CB_CS_WR];
        c.cs_rd_gate = w[CB_CS_RD];
        c.tri_skip   = w[CB_TRI_SKIP];
        c.rdy_high   = w[CB_RDY_HIGH];
        c.rdy_use    = w[CB_RDY_USE];
        c.rw_nodelay = w[CB_NODLY];
        c.ale_long   = w[CB_ALE_LONG];
        c.kind       = w[CB_KIND +: 2];
        c.bus_on     = w[CB_ON];
        return c;
    endfunction

endpackage

// File: rtl/ebc_cfg_reg.sv
module ebc_cfg_reg
    import ebc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output bus_cfg_t         cfg_o
);

    typedef struct packed {
        bus_cfg_t cfg;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    // bits between the gate bits and the wait code carry no function
    logic unused_spare;
    assign unused_spare = ^wdata_i[CB_WAIT-1:CB_CS_WR+1];

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.cfg = cfg_decode(wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;

endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_cfg_t cfg_i,
    input  logic     req_i,
    input  logic     req_we_i,
    input  logic     ready_i,
    output phase_e   phase_o,
    output bus_cfg_t snap_o,
    output logic     we_o,
    output logic     start_o,
    output logic     last_o,
    output logic     done_o
);

    typedef struct packed {
        phase_e            ph;
        bus_cfg_t          snap;
        logic              we;
        logic [WAIT_W-1:0] cnt;
        logic              done;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       data_fin;
    phase_e     after_ale;

    assign data_fin  = st_q.snap.rdy_use ? (ready_i == st_q.snap.rdy_high)
                                         : (st_q.cnt == '0);
    assign after_ale = st_q.snap.rw_nodelay ? PH_DATA : PH_GAP;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        start_o   = 1'b0;
        last_o    = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_i && cfg_i.bus_on) begin
                    start_o   = 1'b1;
                    st_d.snap = cfg_i;
                    st_d.we   = req_we_i;
                    st_d.ph   = PH_ALE;
                end
            end
            PH_ALE: begin
                st_d.cnt = ~st_q.snap.wait_code;
                st_d.ph  = st_q.snap.ale_long ? PH_HOLD : after_ale;
            end
            PH_HOLD: begin
                st_d.cnt = ~st_q.snap.wait_code;
                st_d.ph  = after_ale;
            end
            PH_GAP: begin
                st_d.cnt = ~st_q.snap.wait_code;
                st_d.ph  = PH_DATA;
            end
            PH_DATA: begin
                if (data_fin) begin
                    last_o    = 1'b1;
                    st_d.done = 1'b1;
                    st_d.ph   = st_q.snap.tri_skip ? PH_IDLE : PH_TURN;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_TURN: begin
                st_d.ph = PH_IDLE;
            end
            default: begin
                st_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.ph;
    assign snap_o  = st_q.snap;
    assign we_o    = st_q.we;
    assign done_o  = st_q.done;

endmodule

// File: rtl/ebc_pins.sv
module ebc_pins
    import ebc_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_i,
    input  bus_cfg_t          snap_i,
    input  logic              we_i,
    input  logic              start_i,
    input  logic              last_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] ad_i,
    output logic              ale_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              cs_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned LANE_W = DATA_W / 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } pin_state_t;

    pin_state_t st_d, st_q;

    logic              shared, wide, strobe, active, gate;
    logic [DATA_W-1:0] wr_lane, rd_lane;

    assign shared = snap_i.kind[0];
    assign wide   = snap_i.kind[1];
    assign strobe = (phase_i == PH_DATA);
    assign active = (phase_i == PH_ALE) || (phase_i == PH_HOLD) ||
                    (phase_i == PH_GAP) || strobe;
    assign gate   = we_i ? snap_i.cs_wr_gate : snap_i.cs_rd_gate;

    assign wr_lane = wide ? st_q.wdata
                          : {{(DATA_W-LANE_W){1'b0}}, st_q.wdata[LANE_W-1:0]};
    assign rd_lane = wide ? ad_i
                          : {{(DATA_W-LANE_W){1'b0}}, ad_i[LANE_W-1:0]};

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.addr  = req_addr_i;
            st_d.wdata = req_wdata_i;
        end
        if (last_i && !we_i) begin
            st_d.rdata = rd_lane;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ale_o   = (phase_i == PH_ALE) || (phase_i == PH_HOLD);
        rd_o    = strobe && !we_i;
        wr_o    = strobe && we_i;
        cs_o    = gate ? strobe : active;
        addr_o  = (active && !shared) ? st_q.addr : '0;
        ad_oe_o = (ale_o && shared) || wr_o;
        if (ale_o && shared) begin
            ad_o = st_q.addr[DATA_W-1:0];
        end else if (wr_o) begin
            ad_o = wr_lane;
        end else begin
            ad_o = '0;
        end
    end

    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/ebc_top.sv
module ebc_top
    import ebc_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_ale,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_cs,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_i,
    input  logic              ready_i
);

    bus_cfg_t cfg_live;
    bus_cfg_t snap;
    phase_e   phase;
    logic     cyc_we, start, last;

    ebc_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .cfg_o   (cfg_live)
    );

    ebc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_i    (cfg_live),
        .req_i    (req),
        .req_we_i (req_we),
        .ready_i  (ready_i),
        .phase_o  (phase),
        .snap_o   (snap),
        .we_o     (cyc_we),
        .start_o  (start),
        .last_o   (last),
        .done_o   (done)
    );

    ebc_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_i     (phase),
        .snap_i      (snap),
        .we_i        (cyc_we),
        .start_i     (start),
        .last_i      (last),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .ad_i        (ad_i),
        .ale_o       (bus_ale),
        .rd_o        (bus_rd),
        .wr_o        (bus_wr),
        .cs_o        (bus_cs),
        .addr_o      (addr_o),
        .ad_o        (ad_o),
        .ad_oe_o     (ad_oe),
        .rdata_o     (rdata)
    );

    assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/ebc_chk.sv
module ebc_chk (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic busy,
    input logic done,
    input logic bus_ale,
    input logic bus_rd,
    input logic bus_wr,
    input logic bus_cs,
    input logic ad_oe,
    input logic ready_i,
    input logic live_on,
    input logic s_shared,
    input logic s_ale_long,
    input logic s_rdy_use,
    input logic s_rdy_high,
    input logic s_cs_rd,
    input logic s_cs_wr,
    input logic s_we
);

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    assert_ale_alone_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (!bus_rd && !bus_wr));

    assert_off_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req && !live_on) |=> !busy);

    assert_ale_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_ale) && !s_ale_long) |-> !$past(bus_ale, 2));

    assert_ale_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_ale) && s_ale_long) |-> $past(bus_ale, 2));

    assert_ready_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && s_rdy_use && (ready_i == s_rdy_high))
            |=> (!bus_rd && !bus_wr));

    assert_sep_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale && !s_shared) |-> !ad_oe);

    assert_drive_when_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (bus_wr || bus_ale));

    assert_cs_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_rd && !bus_wr) |-> (busy && !(s_we ? s_cs_wr : s_cs_rd)));

    assert_done_after_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_rd || bus_wr) && !bus_rd && !bus_wr));

endmodule

bind ebc_top ebc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .busy       (busy),
    .done       (done),
    .bus_ale    (bus_ale),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_cs     (bus_cs),
    .ad_oe      (ad_oe),
    .ready_i    (ready_i),
    .live_on    (cfg_live.bus_on),
    .s_shared   (snap.kind[0]),
    .s_ale_long (snap.ale_long),
    .s_rdy_use  (snap.rdy_use),
    .s_rdy_high (snap.rdy_high),
    .s_cs_rd    (snap.cs_rd_gate),
    .s_cs_wr    (snap.cs_wr_gate),
    .s_we       (cyc_we)
);

// File: tb/tb_ebc_top.sv
module tb_ebc_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 20;
    localparam int DATA_W     = 16;

    typedef struct packed {
        logic [15:0]       cfg;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] adin;
        logic [DATA_W-1:0] exp_rd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'hF091, 1'b0, 20'h12345, 16'h0000, 16'h1234, 16'h0034},
        '{16'hC00B, 1'b0, 20'h2A0F0, 16'h0000, 16'hABCD, 16'h00CD},
        '{16'hA215, 1'b1, 20'h30300, 16'hBEEF, 16'h0000, 16'h0000},
        '{16'h7187, 1'b0, 20'h4C0DE, 16'h0000, 16'h5AA5, 16'h5AA5},
        '{16'h0001, 1'b1, 20'h5F00D, 16'h1234, 16'h0000, 16'h0000},
        '{16'hE09F, 1'b1, 20'h6BEAD, 16'h0F0F, 16'h0000, 16'h0000},
        '{16'h5005, 1'b0, 20'h7ACE1, 16'h0000, 16'h8001, 16'h8001},
        '{16'h9203, 1'b1, 20'h81357, 16'h7E81, 16'h0000, 16'h0000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [15:0]       cfg_wdata = '0;
    logic              req = 1'b0;
    logic              req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              busy, done, bus_ale, bus_rd, bus_wr, bus_cs, ad_oe;
    logic [DATA_W-1:0] rdata, ad_o;
    logic [ADDR_W-1:0] addr_o;
    logic [DATA_W-1:0] ad_i = '0;
    logic              ready_i = 1'b0;

    ebc_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .bus_ale(bus_ale),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_cs(bus_cs), .addr_o(addr_o),
        .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .ready_i(ready_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;

    int n_busy, n_ale, n_stb, n_cs, n_pre, n_post, n_mux, n_abad, n_wbad, n_done;
    logic [DATA_W-1:0] cap_rd;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // runs one cycle; rdy_k > 0 raises ready on the k-th strobe clock
    task automatic run_cycle(input logic [15:0] cfg, input logic we,
                             input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] wd,
                             input logic [DATA_W-1:0] adin, input int rdy_k,
                             input bit mid_en, input logic [15:0] mid_cfg);
        bit got_done = 0;
        bit stb_seen = 0;
        bit shared   = cfg[1];
        logic [DATA_W-1:0] exp_w = cfg[2] ? wd : {8'h00, wd[7:0]};
        logic [ADDR_W-1:0] exp_a = shared ? '0 : addr;
        write_cfg(cfg);
        ready_i = ~cfg[6];
        ad_i    = adin;
        req = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        n_busy = 0; n_ale = 0; n_stb = 0; n_cs = 0; n_pre = 0; n_post = 0;
        n_mux = 0; n_abad = 0; n_wbad = 0; n_done = 0; cap_rd = '0;
        for (int i = 0; i < 200; i++) begin
            if (mid_en && i == 0) begin
                cfg_we = 1'b1; cfg_wdata = mid_cfg;
            end else begin
                cfg_we = 1'b0;
            end
            if (busy) n_busy++;
            if (bus_cs) n_cs++;
            if (bus_ale) begin
                n_ale++;
                if (ad_oe && ad_o == addr[DATA_W-1:0]) n_mux++;
            end
            if ((bus_ale || bus_rd || bus_wr || (busy && !stb_seen)) && addr_o != exp_a)
                n_abad++;
            if (bus_rd || bus_wr) begin
                n_stb++;
                stb_seen = 1;
                if (n_stb == rdy_k) ready_i = cfg[6];
            end
            if (bus_wr && (!ad_oe || ad_o != exp_w)) n_wbad++;
            if (busy && !bus_ale && !bus_rd && !bus_wr) begin
                if (stb_seen) n_post++;
                else          n_pre++;
            end
            if (done) begin
                n_done++;
                got_done = 1;
                cap_rd = rdata;
            end
            if (got_done && !busy) break;
            @(negedge clk);
        end
        cfg_we  = 1'b0;
        ready_i = ~cfg[6];
    endtask

    task automatic expect_cycle(input logic [15:0] cfg, input logic we, input int rdy_k,
                                input logic [DATA_W-1:0] exp_rd);
        int e_ale  = 1 + int'(cfg[3]);
        int e_pre  = cfg[4] ? 0 : 1;
        int e_stb  = (rdy_k > 0) ? rdy_k : 16 - int'(cfg[15:12]);
        int e_post = cfg[7] ? 0 : 1;
        bit gate   = we ? cfg[9] : cfg[8];
        int e_cs   = gate ? e_stb : e_ale + e_pre + e_stb;
        check(n_ale == e_ale, "R3 latch clocks", n_ale, e_ale);
        check(n_pre == e_pre, "R4 gap clocks", n_pre, e_pre);
        if (rdy_k > 0) check(n_stb == e_stb, "R6 ready strobe clocks", n_stb, e_stb);
        else           check(n_stb == e_stb, "R5 strobe clocks", n_stb, e_stb);
        check(n_post == e_post, "R7 turnaround clocks", n_post, e_post);
        check(n_busy == e_ale + e_pre + e_stb + e_post, "R7 busy clocks",
              n_busy, e_ale + e_pre + e_stb + e_post);
        check(n_cs == e_cs, "R10 select clocks", n_cs, e_cs);
        check(n_mux == (cfg[1] ? e_ale : 0), "R8 shared address clocks",
              n_mux, cfg[1] ? e_ale : 0);
        check(n_abad == 0, "R8 separate address", n_abad, 0);
        check(n_done == 1, "R11 done pulses", n_done, 1);
        if (we) check(n_wbad == 0, "R9 write data", n_wbad, 0);
        else    check(cap_rd == exp_rd, "R9 R11 read data", int'(cap_rd), int'(exp_rd));
    endtask

    task automatic idle_watch(input logic [15:0] cfg, input string tag);
        int act = 0;
        write_cfg(cfg);
        req = 1'b1; req_we = 1'b0; req_addr = 20'h0ABCD;
        @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (busy || bus_ale || bus_rd || bus_wr || bus_cs || done) act++;
            @(negedge clk);
        end
        check(act == 0, tag, act, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check({busy, done, bus_ale, bus_rd, bus_wr, bus_cs, ad_oe} == 7'b0,
              "R1 reset outputs", {busy, done, bus_ale, bus_rd, bus_wr, bus_cs, ad_oe}, 0);
        check(rdata == '0, "R1 reset rdata", int'(rdata), 0);

        // R1: reset word leaves the bus off, request ignored
        req = 1'b1; req_addr = 20'h00111;
        @(negedge clk);
        req = 1'b0;
        begin
            int act = 0;
            for (int i = 0; i < 20; i++) begin
                if (busy || bus_ale || bus_rd || bus_cs || done) act++;
                @(negedge clk);
            end
            check(act == 0, "R1 reset word bus off", act, 0);
        end

        // R2: enable bit clear with other fields set
        idle_watch(16'hF0FE, "R2 bus off ignores request");

        // table of vectors
        for (int v = 0; v < NV; v++) begin
            run_cycle(VECS[v].cfg, VECS[v].we, VECS[v].addr, VECS[v].wdata,
                      VECS[v].adin, 0, 1'b0, 16'h0);
            expect_cycle(VECS[v].cfg, VECS[v].we, 0, VECS[v].exp_rd);
        end

        // R6: ready high-active ends strobe on 4th clock, code would give 1
        run_cycle(16'hF065, 1'b0, 20'h11111, 16'h0, 16'hC3C3, 4, 1'b0, 16'h0);
        expect_cycle(16'hF065, 1'b0, 4, 16'hC3C3);
        // R6: ready low-active, code would give 16
        run_cycle(16'h0025, 1'b0, 20'h22222, 16'h0, 16'h3C3C, 3, 1'b0, 16'h0);
        expect_cycle(16'h0025, 1'b0, 3, 16'h3C3C);
        // R6: ready active on the first strobe clock
        run_cycle(16'h00A5, 1'b1, 20'h33333, 16'h4242, 16'h0, 1, 1'b0, 16'h0);
        expect_cycle(16'h00A5, 1'b1, 1, 16'h0);

        // R12: write during the cycle changes only the next cycle
        run_cycle(16'h8091, 1'b0, 20'h44444, 16'h0, 16'h0F0F, 0, 1'b1, 16'hF091);
        check(n_stb == 8, "R12 snapshot strobe clocks", n_stb, 8);
        run_cycle(16'hF091, 1'b0, 20'h55555, 16'h0, 16'h00F0, 0, 1'b0, 16'h0);
        check(n_stb == 1, "R12 next cycle strobe clocks", n_stb, 1);

        // R11: rdata held across a write cycle
        run_cycle(16'hF095, 1'b1, 20'h66666, 16'h9999, 16'hFFFF, 0, 1'b0, 16'h0);
        check(rdata == 16'h00F0, "R11 rdata held", int'(rdata), 16'h00F0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule